// File: doc/BRIEF.md
# Quad Serial SRAM Access Engine

This block sits between a simple request port and an external serial SRAM that has already been placed in four-bit mode. Each accepted request becomes one chip-select-low transaction on the nibble bus. The block can write a single byte, read a single byte, or read a sequential burst of up to `MAX_BURST` bytes from a 24-bit start address. For a burst, the memory's auto-incrementing address lets a single header carry the whole run of data. The engine makes the serial clock at half the system clock rate, drives the four data lines with a separate output enable, and pulses `done` when the transaction is over.

Every transaction starts with a header of one opcode byte and three address bytes, and each byte is sent high nibble first. A write puts its data nibbles directly after the address. A read first releases the data lines for one dummy byte, which takes two serial clocks. It then samples two nibbles per returned byte and presents each byte on `rd_valid`/`rd_data`. A typical user is a page-fill path that fetches a 256-byte block behind a small on-chip cache.

Top module: `qsram_engine`

## Requirements
- R1: While reset is held and just after it, `sram_cs_n` is 1, `sram_sck` is 0, `sram_io_oe` is 0, `req_ready` is 1, and `done` and `rd_valid` are 0.
- R2: The first eight nibbles of each transaction are the opcode (0x03 for read, 0x02 for write) followed by the 24-bit address, most significant nibble first, with `sram_io_oe` at 1 throughout.
- R3: While `sram_cs_n` is 0, `sram_sck` spends one system cycle low and then one high for each nibble, starting low. It stays 0 whenever `sram_cs_n` is 1.
- R4: A read holds `sram_io_oe` at 0 for two serial clocks of dummy time after the address and keeps it at 0 until the transaction ends. The lines are never driven while `sram_cs_n` is 1.
- R5: A write sends its data byte as nibbles 8 and 9, high nibble first, with no dummy time, and holds `sram_cs_n` low for exactly 20 system cycles.
- R6: A read of length N returns exactly N bytes on `rd_valid`/`rd_data`, taken from consecutive addresses in rising order. Each byte is built from the nibble sampled first (upper half) and the nibble sampled second (lower half). Two byte strobes are never adjacent.
- R7: A read request with `req_len` equal to 0 is handled as a one-byte read.
- R8: `done` is a single-cycle pulse in the first cycle with `sram_cs_n` back at 1. For reads, the last `rd_valid` falls in that same cycle.
- R9: `sram_cs_n` stays low without a break for the whole transaction: 20 + 4·N cycles for a read of N bytes. After it rises, it stays high for at least one further cycle.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the transaction finishes. Requests presented while `req_ready` is 0 are ignored and start no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is 1 |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 = single-byte write, 0 = read |
| req_addr | input | 24 | Start address |
| req_wdata | input | 8 | Byte to write |
| req_len | input | LEN_W (9) | Read length in bytes, 1..MAX_BURST (0 means 1) |
| rd_valid | output | 1 | One-cycle strobe for a returned byte |
| rd_data | output | 8 | Returned byte |
| done | output | 1 | Transaction complete pulse |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_sck | output | 1 | Serial clock |
| sram_io_out | output | 4 | Nibble driven toward the memory |
| sram_io_oe | output | 1 | Output enable for `sram_io_out` |
| sram_io_in | input | 4 | Nibble returned by the memory |

## Verification
The properties assume that `req_valid` is changed only away from the active clock edge. They also assume that the memory changes `sram_io_in` only after a falling edge of `sram_sck`, so each nibble is stable across the high phase in which the engine samples it. The bench memory model updates its output a short delay after each falling serial clock edge, and it drives data only after the header and dummy nibbles of a read. Read lengths are kept between 0 and `MAX_BURST`, and writes to busy cycles are presented only to exercise R10.

// File: rtl/qsram_pkg.sv
package qsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } qs_state_t;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam int         ADDR_W    = 24;
  localparam int         HDR_NIBS  = 8;
  localparam int         DUMMY_NIBS = 2;

  // nibble idx of the 32-bit header, most significant first
  function automatic logic [3:0] hdr_nibble(input logic [31:0] hdr, input logic [2:0] idx);
    logic [31:0] sh;
    sh = hdr << (4 * idx);
    return sh[31:28];
  endfunction

  function automatic logic [3:0] byte_nibble(input logic [7:0] b, input logic second);
    return second ? b[3:0] : b[7:4];
  endfunction

  // number of data nibbles a request moves on the bus
  function automatic int unsigned data_nibbles(input logic wr, input int unsigned len);
    int unsigned n;
    n = (len == 0) ? 1 : len;
    return wr ? 2 : 2 * n;
  endfunction

endpackage

// File: rtl/qsram_phase.sv
module qsram_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph,
  output logic nib_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph <= 1'b0;
    else if (!run) ph <= 1'b0;
    else           ph <= ~ph;
  end

  assign nib_end = run & ph;
endmodule

// File: rtl/qsram_tx.sv
module qsram_tx
  import qsram_pkg::*;
(
  input  qs_state_t   state,
  input  logic [2:0]  hdr_idx,
  input  logic        second,
  input  logic [31:0] hdr,
  input  logic [7:0]  wdata,
  input  logic        is_write,
  output logic [3:0]  io_out,
  output logic        oe
);
  always_comb begin
    oe     = 1'b0;
    io_out = 4'h0;
    case (state)
      ST_HDR: begin
        oe     = 1'b1;
        io_out = hdr_nibble(hdr, hdr_idx);
      end
      ST_DATA: begin
        if (is_write) begin
          oe     = 1'b1;
          io_out = byte_nibble(wdata, second);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qsram_rx.sv
module qsram_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       second,
  input  logic [3:0] io_in,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic [3:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 4'h0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      if (capture) begin
        if (!second) hi_q <= io_in;
        else begin
          rd_data  <= {hi_q, io_in};
          rd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qsram_engine.sv
module qsram_engine
  import qsram_pkg::*;
#(
  parameter  int MAX_BURST = 256,
  localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [23:0]      req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             sram_cs_n,
  output logic             sram_sck,
  output logic [3:0]       sram_io_out,
  output logic             sram_io_oe,
  input  logic [3:0]       sram_io_in
);
  localparam int CNT_W = LEN_W + 1;

  qs_state_t        state;
  logic [CNT_W-1:0] nib_cnt;
  logic [CNT_W-1:0] nib_limit;
  logic [CNT_W-1:0] data_nibs_q;
  logic [31:0]      hdr_q;
  logic [7:0]       wdata_q;
  logic             is_write_q;

  // named internal events
  logic run;
  logic ph;
  logic nib_end;
  logic nib_last;
  logic accept;
  logic rx_capture;

  assign run        = (state == ST_HDR) || (state == ST_DUMMY) || (state == ST_DATA);
  assign accept     = req_valid && (state == ST_IDLE);
  assign rx_capture = (state == ST_DATA) && !is_write_q && nib_end;

  always_comb begin
    case (state)
      ST_HDR:   nib_limit = CNT_W'(HDR_NIBS);
      ST_DUMMY: nib_limit = CNT_W'(DUMMY_NIBS);
      default:  nib_limit = data_nibs_q;
    endcase
  end
  assign nib_last = (nib_cnt == nib_limit - 1'b1);

  qsram_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ph      (ph),
    .nib_end (nib_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      nib_cnt     <= '0;
      data_nibs_q <= '0;
      hdr_q       <= '0;
      wdata_q     <= '0;
      is_write_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state       <= ST_HDR;
            nib_cnt     <= '0;
            is_write_q  <= req_write;
            wdata_q     <= req_wdata;
            hdr_q       <= {req_write ? OP_WRITE : OP_READ, req_addr};
            data_nibs_q <= CNT_W'(data_nibbles(req_write, 32'(req_len)));
          end
        end
        ST_HDR, ST_DUMMY, ST_DATA: begin
          if (nib_end) begin
            if (nib_last) begin
              nib_cnt <= '0;
              case (state)
                ST_HDR:   state <= is_write_q ? ST_DATA : ST_DUMMY;
                ST_DUMMY: state <= ST_DATA;
                default:  state <= ST_GAP;
              endcase
            end else begin
              nib_cnt <= nib_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  qsram_tx u_tx (
    .state    (state),
    .hdr_idx  (nib_cnt[2:0]),
    .second   (nib_cnt[0]),
    .hdr      (hdr_q),
    .wdata    (wdata_q),
    .is_write (is_write_q),
    .io_out   (sram_io_out),
    .oe       (sram_io_oe)
  );

  qsram_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (rx_capture),
    .second   (nib_cnt[0]),
    .io_in    (sram_io_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_GAP);
  assign sram_cs_n = !run;
  assign sram_sck  = ph;
endmodule

// File: rtl/qsram_engine_chk.sv
module qsram_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic done,
  input logic sram_cs_n,
  input logic sram_sck,
  input logic sram_io_oe,
  input logic nib_end
);
  // R3: serial clock quiet outside a transaction
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n |-> !sram_sck);

  // R3: a high phase lasts one cycle
  a_r3_sck_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && sram_sck) |=> !sram_sck);

  // R3: nibble boundaries only during the high phase
  a_r3_nib_end_high: assert property (@(posedge clk) disable iff (!rst_n)
    nib_end |-> (sram_sck && !sram_cs_n));

  // R4: lines released while deselected
  a_r4_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n |-> !sram_io_oe);

  // R4: once released inside a transaction, not driven again
  a_r4_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_io_oe) && !sram_cs_n) |=> !sram_io_oe);

  // R6: byte strobes never adjacent
  a_r6_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8: completion pulse with select released
  a_r8_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sram_cs_n);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: select stays high at least one more cycle after release
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |=> sram_cs_n);

  // R10: accepted request starts the bus next cycle and drops ready
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !sram_cs_n));
endmodule

bind qsram_engine qsram_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .done       (done),
  .sram_cs_n  (sram_cs_n),
  .sram_sck   (sram_sck),
  .sram_io_oe (sram_io_oe),
  .nib_end    (nib_end)
);

// File: tb/qsram_engine_test.sv
`timescale 1ns/1ps
module qsram_engine_test;
  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [23:0]      req_addr = '0;
  logic [7:0]       req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             done;
  logic             sram_cs_n;
  logic             sram_sck;
  logic [3:0]       sram_io_out;
  logic             sram_io_oe;
  logic [3:0]       sram_io_in = 4'h0;

  always #2 clk = ~clk;

  qsram_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .sram_cs_n(sram_cs_n), .sram_sck(sram_sck), .sram_io_out(sram_io_out),
    .sram_io_oe(sram_io_oe), .sram_io_in(sram_io_in)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + 5);
  endfunction

  // memory model and expected copy
  logic [7:0] mem     [0:4095];
  logic [7:0] ref_mem [0:4095];
  initial for (int i = 0; i < 4096; i++) begin
    mem[i]     = pat(i);
    ref_mem[i] = pat(i);
  end

  int          total_rises = 0;
  int          base = 0;
  int          txn_cnt = 0;
  logic [31:0] hdr_sh = '0;
  logic [7:0]  m_cmd = '0;
  logic [23:0] m_addr = '0;
  logic [7:0]  wbyte = '0;
  bit          hdr_oe_bad = 0;
  bit          rd_oe_bad = 0;

  always @(negedge sram_cs_n) begin
    base = total_rises;
    txn_cnt++;
  end

  always @(posedge sram_sck) begin
    int rel;
    rel = total_rises - base;
    if (rel < 8) begin
      if (!sram_io_oe) hdr_oe_bad = 1;
      hdr_sh = {hdr_sh[27:0], sram_io_out};
      if (rel == 7) begin
        m_cmd  = hdr_sh[31:24];
        m_addr = hdr_sh[23:0];
      end
    end else if (m_cmd == 8'h02) begin
      if (rel == 8) wbyte[7:4] = sram_io_out;
      else if (rel == 9) begin
        wbyte[3:0] = sram_io_out;
        mem[m_addr[11:0]] = wbyte;
      end
    end else if (sram_io_oe) rd_oe_bad = 1;
    total_rises++;
  end

  always @(negedge sram_sck) begin
    int rel;
    int j;
    logic [7:0] b;
    rel = total_rises - base;
    if (!sram_cs_n && m_cmd == 8'h03 && rel >= 10) begin
      j = rel - 10;
      b = mem[(int'(m_addr) + j / 2) & 12'hFFF];
      #1 sram_io_in = (j % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  // port monitors
  int         cs_low_cnt = 0;
  int         rcnt = 0;
  logic [7:0] rbuf [0:299];
  int         done_cnt = 0;
  bit         done_with_last = 0;
  bit         sck_bad = 0;
  logic       prev_sck = 1'b0;
  logic       prev_cs_high = 1'b1;

  always @(negedge clk) begin
    if (!sram_cs_n) begin
      cs_low_cnt++;
      if (sram_sck != (prev_cs_high ? 1'b0 : ~prev_sck)) sck_bad = 1;
    end else if (sram_sck) sck_bad = 1;
    prev_sck     = sram_sck;
    prev_cs_high = sram_cs_n;
    if (rd_valid && rcnt < 300) begin
      rbuf[rcnt] = rd_data;
      rcnt++;
    end
    if (done) begin
      done_cnt++;
      done_with_last = rd_valid;
    end
  end

  task automatic clear_mon();
    cs_low_cnt = 0; rcnt = 0; done_cnt = 0; done_with_last = 0;
    sck_bad = 0; hdr_oe_bad = 0; rd_oe_bad = 0;
  endtask

  task automatic issue(input bit wr, input logic [23:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    clear_mon();
    req_write = wr; req_addr = a; req_wdata = d; req_len = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(sram_cs_n == 1'b1, "R1 cs_n in reset", sram_cs_n, 1);
    chk(sram_sck == 1'b0, "R1 sck in reset", sram_sck, 0);
    chk(sram_io_oe == 1'b0, "R1 oe in reset", sram_io_oe, 0);
    chk(req_ready == 1'b1 && !done && !rd_valid, "R1 ready/done/valid in reset",
        {req_ready, done, rd_valid}, 3'b100);
  endtask

  task automatic t_write(input logic [23:0] a, input logic [7:0] d);
    issue(1'b1, a, d, 0);
    ref_mem[a[11:0]] = d;
    wait_done();
    chk(m_cmd == 8'h02, "R2 write opcode", m_cmd, 8'h02);
    chk(m_addr == a, "R2 write address", m_addr, a);
    chk(!hdr_oe_bad, "R2 header driven", hdr_oe_bad, 0);
    chk(mem[a[11:0]] == d, "R5 written byte", mem[a[11:0]], d);
    chk(cs_low_cnt == 20, "R5 write select length", cs_low_cnt, 20);
    chk(done_cnt == 1, "R8 write done pulse", done_cnt, 1);
    chk(!sck_bad, "R3 sck pattern write", sck_bad, 0);
  endtask

  task automatic t_read(input logic [23:0] a, input int len);
    int n;
    n = (len == 0) ? 1 : len;
    issue(1'b0, a, 8'h00, len);
    wait_done();
    chk(m_cmd == 8'h03, "R2 read opcode", m_cmd, 8'h03);
    chk(m_addr == a, "R2 read address", m_addr, a);
    chk(!hdr_oe_bad, "R2 header driven", hdr_oe_bad, 0);
    chk(!rd_oe_bad, "R4 released after address", rd_oe_bad, 0);
    chk(rcnt == n, (len == 0) ? "R7 zero length byte count" : "R6 byte count", rcnt, n);
    for (int i = 0; i < n && i < rcnt; i++) begin
      logic [7:0] e;
      e = ref_mem[(int'(a) + i) & 12'hFFF];
      chk(rbuf[i] == e, "R6 byte value", rbuf[i], e);
    end
    chk(cs_low_cnt == 20 + 4 * n, "R9 read select length", cs_low_cnt, 20 + 4 * n);
    chk(done_cnt == 1 && done_with_last, "R8 done with last byte",
        {done_cnt[3:0], done_with_last}, 5'b00011);
    chk(!sck_bad, "R3 sck pattern read", sck_bad, 0);
  endtask

  task automatic t_busy();
    int t0;
    logic [11:0] b_idx;
    b_idx = 12'h321;
    t0 = txn_cnt;
    issue(1'b0, 24'h00_0400, 8'h00, 8);
    repeat (6) @(negedge clk);
    req_write = 1'b1; req_addr = 24'h00_0321; req_wdata = 8'h5A; req_len = '0;
    req_valid = 1'b1;
    repeat (1) @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    repeat (9) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk(txn_cnt == t0 + 1, "R10 busy request ignored", txn_cnt - t0, 1);
    chk(mem[b_idx] == ref_mem[b_idx], "R10 memory untouched", mem[b_idx], ref_mem[b_idx]);
    chk(rcnt == 8, "R10 read unaffected", rcnt, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(24'h12_3456, 8'hC3);
    t_read(24'h12_3456, 1);
    t_read(24'h7A_00FE, 5);
    t_read(24'h00_1200, 256);
    t_read(24'h45_0010, 0);
    t_write(24'hFF_FFFF, 8'h9E);
    t_read(24'hFF_FFFE, 2);
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule